// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatch Controller

This block sits beside a processor's exception logic and decides, on every clock, whether the highest pending interrupt level may interrupt the current context. When it may, the block commits every processor-state update that taking the interrupt implies on one clock edge. It then raises a one-cycle taken strobe and presents the address the fetch unit must jump to.

Levels above 1 take a direct path: the block saves the interrupted PC and status word into per-level save registers, raises the status word's level field to the taken level, and jumps to that level's vector. Level 1 takes an exception path: the block records a level-1 interrupt cause and classifies the event as a user, kernel or double exception from the mode bits. It saves the PC, or on a double exception routes it to a dedicated double-exception PC register when one is configured, and jumps to the matching exception vector. Vector addresses are laid out from a default base and a per-level stride. They can optionally be relocated at run time against a vector-base input.

All inputs are plain register values sampled each cycle. There is no stream interface, so no valid/ready handshake or back-pressure applies. Outputs are registered state that changes only on a taken interrupt.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt at pending level L (`pend_lvl_i`) is taken only if L is strictly greater than the status level field `ps_i[3:0]`, 1 <= L <= NUM_LEVELS, and the AND of the mask of level L (`lvl_mask_i[(L-1)*32 +: 32]`), `intset_i` and `intenable_i` is nonzero.
- R2: On a taken level L > 1, the saved PC of level L (`epc_o[(L-1)*32 +: 32]`) receives `pc_i`, the saved status of level L (`eps_o[(L-2)*32 +: 32]`) receives `ps_i`, and `exc_kind_o` becomes 0 (none).
- R3: On a taken level L > 1, `ps_o` equals `ps_i` with bits [3:0] replaced by L and bit 4 (exception mode) set; all other bits are kept.
- R4: On a taken level L > 1, `new_pc_o` is the level vector DEF_VBASE + L*VEC_STRIDE (before relocation).
- R5: On a taken level 1, `exccause_o` becomes L1_CAUSE (default 4). No other take writes it.
- R6: On a taken level 1 with `ps_i[4]` set, `exc_kind_o` becomes 3 (double). `pc_i` goes to `depc_o` when HAS_DEPC is nonzero and to the level-1 saved PC otherwise. `new_pc_o` is DEF_VBASE + DBL_OFF.
- R7: On a taken level 1 with `ps_i[4]` clear, the level-1 saved PC receives `pc_i`. `exc_kind_o` becomes 1 (user) if `ps_i[5]` is set and 2 (kernel) otherwise. `new_pc_o` is DEF_VBASE + USER_OFF or DEF_VBASE + KERN_OFF respectively. In both level-1 cases `ps_o` is `ps_i` with bit 4 set.
- R8: With RELOC_EN nonzero every vector becomes vector - DEF_VBASE + `vecbase_i`; with RELOC_EN zero `vecbase_i` has no effect.
- R9: `taken_o` is high for exactly the cycle after each cycle in which the condition of R1 holds, and all updates of that take appear in that same cycle.
- R10: In any cycle after one where the condition of R1 fails, every output other than `taken_o` keeps its previous value and `taken_o` is low.
- R11: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_lvl_i | input | 4 | Highest pending interrupt level |
| ps_i | input | 32 | Current status word: [3:0] level, [4] exception mode, [5] user mode |
| lvl_mask_i | input | NUM_LEVELS*32 | Per-level line masks, level L at slice L-1 |
| intset_i | input | 32 | Pending interrupt lines |
| intenable_i | input | 32 | Enabled interrupt lines |
| pc_i | input | 32 | PC of the interrupted instruction |
| vecbase_i | input | 32 | Run-time vector base |
| epc_o | output | NUM_LEVELS*32 | Saved PC per level, level L at slice L-1 |
| eps_o | output | (NUM_LEVELS-1)*32 | Saved status per level 2..N, level L at slice L-2 |
| depc_o | output | 32 | Double-exception saved PC |
| ps_o | output | 32 | Updated status word |
| exccause_o | output | 6 | Exception cause |
| exc_kind_o | output | 2 | 0 none, 1 user, 2 kernel, 3 double |
| new_pc_o | output | 32 | Redirect target |
| taken_o | output | 1 | One-cycle pulse on a taken interrupt |

## Verification
The bench sweeps every pending level 0..15 against every current level 0..7. This separates the strict-greater comparison from an off-by-one and shows that levels beyond the configured count are rejected. Each pair runs under all four combinations of the exception-mode and user-mode bits, which distinguishes the user, kernel and double classifications and the high-level path, where those bits only pass through. Four pending/enable patterns (all on, enable off, only a line of the pending level, only a line of another level) separate the three-way AND from any partial check. The vector base alternates between the default base and a shifted one. A second instance without a double-exception register and without relocation runs the same stimulus, so PC routing and relocation are each seen in both variants.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;
  localparam int LVL_W    = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_USER   = 2'd1,
    KIND_KERNEL = 2'd2,
    KIND_DOUBLE = 2'd3
  } exc_kind_e;

  typedef struct packed {
    logic             take;
    logic             high;
    logic [LVL_W-1:0] lvl;
  } irq_dec_t;
endpackage

// File: rtl/irqd_qualify.sv
`timescale 1ns/1ps
module irqd_qualify
  import irqd_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  parameter int NUM_LINES  = 32,
  localparam int MASK_W    = NUM_LEVELS * NUM_LINES
) (
  input  logic [LVL_W-1:0]     pend_lvl_i,
  input  logic [LVL_W-1:0]     cur_lvl_i,
  input  logic [MASK_W-1:0]    lvl_mask_i,
  input  logic [NUM_LINES-1:0] intset_i,
  input  logic [NUM_LINES-1:0] intenable_i,
  output irq_dec_t             dec_o
);
  logic [NUM_LEVELS-1:0] lvl_hit;
  logic [NUM_LINES-1:0]  live;

  assign live = intset_i & intenable_i;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_hit
    assign lvl_hit[k] = |(lvl_mask_i[k*NUM_LINES +: NUM_LINES] & live);
  end

  always_comb begin
    logic sel_hit;
    sel_hit = 1'b0;
    for (int k = 1; k <= NUM_LEVELS; k++) begin
      if (pend_lvl_i == LVL_W'(k)) sel_hit = lvl_hit[k-1];
    end
    dec_o.lvl  = pend_lvl_i;
    dec_o.high = (pend_lvl_i > LVL_W'(1));
    dec_o.take = sel_hit && (pend_lvl_i > cur_lvl_i);
  end
endmodule

// File: rtl/irqd_vector.sv
`timescale 1ns/1ps
module irqd_vector
  import irqd_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] DEF_VBASE  = 32'h4000_0000,
  parameter logic [31:0] VEC_STRIDE = 32'h0000_0040,
  parameter logic [31:0] USER_OFF   = 32'h0000_0340,
  parameter logic [31:0] KERN_OFF   = 32'h0000_0300,
  parameter logic [31:0] DBL_OFF    = 32'h0000_03C0,
  parameter bit          RELOC_EN   = 1'b1
) (
  input  logic             high_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  exc_kind_e        kind_i,
  input  logic [XLEN-1:0]  vecbase_i,
  output logic [XLEN-1:0]  target_o
);
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] lvl_ext;

  assign lvl_ext = {{(XLEN-LVL_W){1'b0}}, lvl_i};

  always_comb begin
    if (high_i) begin
      raw = XLEN'(DEF_VBASE) + lvl_ext * XLEN'(VEC_STRIDE);
    end else begin
      unique case (kind_i)
        KIND_USER:   raw = XLEN'(DEF_VBASE) + XLEN'(USER_OFF);
        KIND_DOUBLE: raw = XLEN'(DEF_VBASE) + XLEN'(DBL_OFF);
        default:     raw = XLEN'(DEF_VBASE) + XLEN'(KERN_OFF);
      endcase
    end
  end

  if (RELOC_EN) begin : g_reloc
    assign target_o = raw - XLEN'(DEF_VBASE) + vecbase_i;
  end else begin : g_fixed
    assign target_o = raw;
  end
endmodule

// File: rtl/irqd_save.sv
`timescale 1ns/1ps
module irqd_save
  import irqd_pkg::*;
#(
  parameter int          NUM_LEVELS = 7,
  parameter int          XLEN       = 32,
  parameter int          CAUSE_W    = 6,
  parameter logic [31:0] L1_CAUSE   = 32'd4,
  localparam int EPC_W = NUM_LEVELS * XLEN,
  localparam int EPS_W = (NUM_LEVELS - 1) * XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   epc_sel_i,
  input  logic [LVL_W-1:0]   eps_sel_i,
  input  logic               depc_we_i,
  input  logic               cause_we_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    ps_cur_i,
  input  logic [XLEN-1:0]    ps_nxt_i,
  input  exc_kind_e          kind_i,
  input  logic [XLEN-1:0]    target_i,
  output logic [EPC_W-1:0]   epc_o,
  output logic [EPS_W-1:0]   eps_o,
  output logic [XLEN-1:0]    depc_o,
  output logic [XLEN-1:0]    ps_o,
  output logic [CAUSE_W-1:0] exccause_o,
  output logic [1:0]         exc_kind_o,
  output logic [XLEN-1:0]    new_pc_o,
  output logic               taken_o
);
  for (genvar k = 1; k <= NUM_LEVELS; k++) begin : g_epc
    logic [XLEN-1:0] epc_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   epc_q <= '0;
      else if (take_i && epc_sel_i == LVL_W'(k))    epc_q <= pc_i;
    end
    assign epc_o[(k-1)*XLEN +: XLEN] = epc_q;
  end

  for (genvar k = 2; k <= NUM_LEVELS; k++) begin : g_eps
    logic [XLEN-1:0] eps_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   eps_q <= '0;
      else if (take_i && eps_sel_i == LVL_W'(k))    eps_q <= ps_cur_i;
    end
    assign eps_o[(k-2)*XLEN +: XLEN] = eps_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depc_o     <= '0;
      ps_o       <= '0;
      exccause_o <= '0;
      exc_kind_o <= KIND_NONE;
      new_pc_o   <= '0;
      taken_o    <= 1'b0;
    end else begin
      taken_o <= take_i;
      if (take_i) begin
        ps_o       <= ps_nxt_i;
        exc_kind_o <= kind_i;
        new_pc_o   <= target_i;
        if (depc_we_i)  depc_o     <= pc_i;
        if (cause_we_i) exccause_o <= CAUSE_W'(L1_CAUSE);
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int          NUM_LEVELS = 7,
  parameter int          NUM_LINES  = 32,
  parameter int          XLEN       = 32,
  parameter int          CAUSE_W    = 6,
  parameter logic [31:0] L1_CAUSE   = 32'd4,
  parameter bit          HAS_DEPC   = 1'b1,
  parameter bit          RELOC_EN   = 1'b1,
  parameter logic [31:0] DEF_VBASE  = 32'h4000_0000,
  parameter logic [31:0] VEC_STRIDE = 32'h0000_0040,
  parameter logic [31:0] USER_OFF   = 32'h0000_0340,
  parameter logic [31:0] KERN_OFF   = 32'h0000_0300,
  parameter logic [31:0] DBL_OFF    = 32'h0000_03C0,
  localparam int MASK_W = NUM_LEVELS * NUM_LINES,
  localparam int EPC_W  = NUM_LEVELS * XLEN,
  localparam int EPS_W  = (NUM_LEVELS - 1) * XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   pend_lvl_i,
  input  logic [XLEN-1:0]    ps_i,
  input  logic [MASK_W-1:0]  lvl_mask_i,
  input  logic [NUM_LINES-1:0] intset_i,
  input  logic [NUM_LINES-1:0] intenable_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    vecbase_i,
  output logic [EPC_W-1:0]   epc_o,
  output logic [EPS_W-1:0]   eps_o,
  output logic [XLEN-1:0]    depc_o,
  output logic [XLEN-1:0]    ps_o,
  output logic [CAUSE_W-1:0] exccause_o,
  output logic [1:0]         exc_kind_o,
  output logic [XLEN-1:0]    new_pc_o,
  output logic               taken_o
);
  irq_dec_t        dec;
  exc_kind_e       kind_n;
  logic [XLEN-1:0] ps_n;
  logic [XLEN-1:0] target;
  logic [LVL_W-1:0] epc_sel, eps_sel;
  logic            depc_we, cause_we;
  logic            excm, um;

  assign excm = ps_i[EXCM_BIT];
  assign um   = ps_i[UM_BIT];

  irqd_qualify #(.NUM_LEVELS(NUM_LEVELS), .NUM_LINES(NUM_LINES)) u_qual (
    .pend_lvl_i (pend_lvl_i),
    .cur_lvl_i  (ps_i[LVL_W-1:0]),
    .lvl_mask_i (lvl_mask_i),
    .intset_i   (intset_i),
    .intenable_i(intenable_i),
    .dec_o      (dec)
  );

  always_comb begin
    kind_n   = KIND_NONE;
    ps_n     = ps_i;
    epc_sel  = '0;
    eps_sel  = '0;
    depc_we  = 1'b0;
    cause_we = 1'b0;
    ps_n[EXCM_BIT] = 1'b1;
    if (dec.high) begin
      epc_sel = dec.lvl;
      eps_sel = dec.lvl;
      ps_n[LVL_W-1:0] = dec.lvl;
    end else begin
      cause_we = 1'b1;
      if (excm) begin
        kind_n = KIND_DOUBLE;
        if (HAS_DEPC) depc_we = 1'b1;
        else          epc_sel = LVL_W'(1);
      end else begin
        epc_sel = LVL_W'(1);
        kind_n  = um ? KIND_USER : KIND_KERNEL;
      end
    end
  end

  irqd_vector #(
    .XLEN(XLEN), .DEF_VBASE(DEF_VBASE), .VEC_STRIDE(VEC_STRIDE),
    .USER_OFF(USER_OFF), .KERN_OFF(KERN_OFF), .DBL_OFF(DBL_OFF),
    .RELOC_EN(RELOC_EN)
  ) u_vec (
    .high_i   (dec.high),
    .lvl_i    (dec.lvl),
    .kind_i   (kind_n),
    .vecbase_i(vecbase_i),
    .target_o (target)
  );

  irqd_save #(
    .NUM_LEVELS(NUM_LEVELS), .XLEN(XLEN), .CAUSE_W(CAUSE_W), .L1_CAUSE(L1_CAUSE)
  ) u_save (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (dec.take),
    .epc_sel_i (epc_sel),
    .eps_sel_i (eps_sel),
    .depc_we_i (depc_we),
    .cause_we_i(cause_we),
    .pc_i      (pc_i),
    .ps_cur_i  (ps_i),
    .ps_nxt_i  (ps_n),
    .kind_i    (kind_n),
    .target_i  (target),
    .epc_o     (epc_o),
    .eps_o     (eps_o),
    .depc_o    (depc_o),
    .ps_o      (ps_o),
    .exccause_o(exccause_o),
    .exc_kind_o(exc_kind_o),
    .new_pc_o  (new_pc_o),
    .taken_o   (taken_o)
  );

  AST_TAKE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ($past(pend_lvl_i) > $past(ps_i[LVL_W-1:0])) &&
                ($past(pend_lvl_i) <= LVL_W'(NUM_LEVELS))); // R1
  AST_HIGH_LEVEL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && $past(pend_lvl_i) > LVL_W'(1)) |->
      (ps_o[LVL_W-1:0] == $past(pend_lvl_i)) && (exc_kind_o == KIND_NONE)); // R3
  AST_EXCM_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ps_o[EXCM_BIT]); // R7
  AST_L1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && $past(pend_lvl_i) == LVL_W'(1)) |->
      (exccause_o == CAUSE_W'(L1_CAUSE)) && (exc_kind_o != KIND_NONE)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> $stable(ps_o) && $stable(new_pc_o) && $stable(epc_o) &&
                 $stable(eps_o) && $stable(depc_o) && $stable(exccause_o) &&
                 $stable(exc_kind_o)); // R10
endmodule

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;
  localparam int NL = 7;
  localparam logic [31:0] DEFB = 32'h4000_0000;
  localparam logic [31:0] STR  = 32'h40;
  localparam logic [31:0] UOFF = 32'h340;
  localparam logic [31:0] KOFF = 32'h300;
  localparam logic [31:0] DOFF = 32'h3C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]      pend;
  logic [31:0]     ps, pc, vb, iset, ien;
  logic [NL*32-1:0] mask;

  logic [NL*32-1:0]     epc [2];
  logic [(NL-1)*32-1:0] eps [2];
  logic [31:0] depc [2], pso [2], npc [2];
  logic [5:0]  cause [2];
  logic [1:0]  kind [2];
  logic        tk [2];

  irq_dispatch #(.HAS_DEPC(1'b1), .RELOC_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_lvl_i(pend), .ps_i(ps), .lvl_mask_i(mask),
    .intset_i(iset), .intenable_i(ien), .pc_i(pc), .vecbase_i(vb),
    .epc_o(epc[0]), .eps_o(eps[0]), .depc_o(depc[0]), .ps_o(pso[0]),
    .exccause_o(cause[0]), .exc_kind_o(kind[0]), .new_pc_o(npc[0]), .taken_o(tk[0]));

  irq_dispatch #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .pend_lvl_i(pend), .ps_i(ps), .lvl_mask_i(mask),
    .intset_i(iset), .intenable_i(ien), .pc_i(pc), .vecbase_i(vb),
    .epc_o(epc[1]), .eps_o(eps[1]), .depc_o(depc[1]), .ps_o(pso[1]),
    .exccause_o(cause[1]), .exc_kind_o(kind[1]), .new_pc_o(npc[1]), .taken_o(tk[1]));

  // expected state per configuration
  logic [NL*32-1:0]     x_epc [2];
  logic [(NL-1)*32-1:0] x_eps [2];
  logic [31:0] x_depc [2], x_ps [2], x_npc [2];
  logic [5:0]  x_cause [2];
  logic [1:0]  x_kind [2];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reloc(int c, logic [31:0] v);
    return (c == 0) ? v - DEFB + vb : v;
  endfunction

  initial begin
    for (int k = 1; k <= NL; k++)
      for (int i = 0; i < 32; i++)
        mask[(k-1)*32 + i] = ((i % NL) + 1 == k);
    pend = '0; ps = '0; pc = '0; vb = DEFB; iset = '0; ien = '0;
    for (int c = 0; c < 2; c++) begin
      x_epc[c] = '0; x_eps[c] = '0; x_depc[c] = '0; x_ps[c] = '0;
      x_npc[c] = '0; x_cause[c] = '0; x_kind[c] = '0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin  // R11 reset state
      chk("R11", {epc[c], eps[c][31:0]}, '0);
      chk("R11", {depc[c], pso[c], npc[c], cause[c], kind[c], tk[c]}, '0);
    end
    rst_n = 1'b1;
    begin
      int trial = 0;
      bit prev_take = 1'b0;
      for (int pl = 0; pl < 16; pl++)
        for (int cl = 0; cl < 8; cl++)
          for (int md = 0; md < 4; md++)
            for (int en = 0; en < 4; en++) begin
              bit excm, um, hit, acc;
              logic [31:0] lvlmask, v;
              excm = md[0]; um = md[1];
              pend = 4'(pl);
              ps = 32'hA5C3_0000 | (32'(trial & 8'hFF) << 8) | (32'(um) << 5) | (32'(excm) << 4) | 32'(cl);
              pc = 32'h1000_0000 + 32'(trial) * 4;
              vb = trial[0] ? 32'h2000_1000 : DEFB;
              case (en)
                0: begin iset = '1; ien = '1; end
                1: begin iset = '1; ien = '0; end
                2: begin iset = (pl >= 1 && pl <= NL) ? 32'(1) << (pl - 1) : 32'(1); ien = '1; end
                default: begin iset = 32'(1) << (pl % NL); ien = '1; end
              endcase
              lvlmask = '0;
              for (int i = 0; i < 32; i++) lvlmask[i] = ((i % NL) + 1 == pl);
              hit = |(lvlmask & iset & ien);
              acc = hit && (pl > cl) && (pl >= 1) && (pl <= NL);
              for (int c = 0; c < 2; c++) begin
                if (acc) begin
                  if (pl > 1) begin
                    x_epc[c][(pl-1)*32 +: 32] = pc;
                    x_eps[c][(pl-2)*32 +: 32] = ps;
                    x_ps[c] = (ps & ~32'hF) | 32'(pl) | 32'h10;
                    x_kind[c] = 2'd0;
                    x_npc[c] = reloc(c, DEFB + 32'(pl) * STR);
                  end else begin
                    x_cause[c] = 6'd4;
                    x_ps[c] = ps | 32'h10;
                    if (excm) begin
                      x_kind[c] = 2'd3;
                      if (c == 0) x_depc[c] = pc; else x_epc[c][31:0] = pc;
                      v = DEFB + DOFF;
                    end else begin
                      x_epc[c][31:0] = pc;
                      x_kind[c] = um ? 2'd1 : 2'd2;
                      v = DEFB + (um ? UOFF : KOFF);
                    end
                    x_npc[c] = reloc(c, v);
                  end
                end
              end
              @(negedge clk);
              for (int c = 0; c < 2; c++) begin
                if (!acc) begin
                  chk(prev_take ? "R9" : "R1", 256'(tk[c]), 256'(0));
                  chk("R10", {epc[c], pso[c]}, {x_epc[c], x_ps[c]});
                  chk("R10", {eps[c], depc[c], npc[c], cause[c], kind[c]},
                             {x_eps[c], x_depc[c], x_npc[c], x_cause[c], x_kind[c]});
                end else begin
                  chk("R9", 256'(tk[c]), 256'(1));
                  if (pl > 1) begin
                    chk("R2", {epc[c], eps[c], kind[c]}, {x_epc[c], x_eps[c], x_kind[c]});
                    chk("R3", 256'(pso[c]), 256'(x_ps[c]));
                    chk(trial[0] && c == 0 ? "R8" : "R4", 256'(npc[c]), 256'(x_npc[c]));
                  end else begin
                    chk("R5", 256'(cause[c]), 256'(x_cause[c]));
                    if (excm) chk("R6", {epc[c], depc[c], kind[c], npc[c]}, {x_epc[c], x_depc[c], x_kind[c], x_npc[c]});
                    else      chk("R7", {epc[c], kind[c], npc[c], pso[c]}, {x_epc[c], x_kind[c], x_npc[c], x_ps[c]});
                  end
                end
              end
              prev_take = acc;
              trial++;
            end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule